// File: doc/BRIEF.md
# Trigger-Qualified Up/Down Counter

This block is a counter that runs on the system clock. An external trigger line decides whether it may advance, under a programmable enable mode. In the free mode the counter ignores the trigger. In the gated mode the counter follows the synchronised trigger level. In the start mode the first synchronised rising edge arms a latch, and the counter then runs for as long as that mode stays selected. The trigger never clocks the counter. It only qualifies the advance.

The counting direction comes from its own input and is the same in every mode. The count wraps between zero and a programmable reload limit. A load strobe places a preset value into the count. A running flag shows in each cycle whether the present mode and trigger state let the counter advance.

Top module: `trig_cnt`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is released, `count` reads 0 and the enable mode is the free mode (code 0), so `running` is 1.
- R2: In mode code 0 the counter advances on every clock edge, whatever the trigger level.
- R3: In mode code 5 the counter advances only while the synchronised trigger level is high, and holds while it is low. A change on `trigIn` reaches the synchroniser output after two clock edges, and the count responds on the edge after that.
- R4: In mode code 6, a synchronised rising edge of the trigger sets an enable latch one edge later. From then on the counter advances on every edge. Later trigger edges neither restart nor reset the count, and a trigger that is high without a new rising edge does not set the latch.
- R5: A pulse on `modeWr` loads `modeIn` into the mode register on that edge and clears the start latch. After the mode is rewritten to 6, a fresh rising edge is needed before counting resumes.
- R6: Any mode code other than 0, 5 and 6 disables counting, and the count holds.
- R7: With `dirUp`=1 the count goes up and wraps from `reloadLim` to 0. With `dirUp`=0 it goes down and wraps from 0 to `reloadLim`. This holds in every enable mode.
- R8: `loadStb` copies `presetVal` into the count on the next edge. It takes priority over counting and works in any mode.
- R9: `running` is 1 exactly in the cycles in which the registered mode, the synchronised trigger and the start latch allow an advance on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock of the counter |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Asynchronous trigger line |
| modeIn | input | 3 | Enable-mode code: 0 free, 5 gated, 6 start, other values idle |
| modeWr | input | 1 | Write strobe for the mode register |
| dirUp | input | 1 | 1 counts up, 0 counts down |
| presetVal | input | CNT_W | Value placed by a load |
| loadStb | input | 1 | Load strobe |
| reloadLim | input | CNT_W | Wrap limit of the count |
| count | output | CNT_W | Current count |
| running | output | 1 | Counter may advance on the next edge |

## Verification
The bench steps the trigger against the two-flop synchroniser and samples the count on the exact edge where a gated or latched enable should first take effect. A counter that used the raw trigger, or that dropped a stage, would be off by one count. In start mode it sends repeated rising edges and a steady high level after a mode rewrite. A design that re-armed on the level, restarted the count or kept the old latch would stop, jump or keep counting at the wrong point. It also checks the wraps at both ends of the range, a reload limit changed mid-run, a load that coincides with an advance, and an unused mode code, where a wrong priority or decode would show an extra step.

// File: rtl/trig_cnt_pkg.sv
package trig_cnt_pkg;

  localparam logic [2:0] MODE_FREE  = 3'd0;
  localparam logic [2:0] MODE_GATE  = 3'd5;
  localparam logic [2:0] MODE_START = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic countUp;
  } cntStrb_t;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trigRaw,
  output logic trigLevel,
  output logic trigRise
);

  logic [STAGES-1:0] syncChain;
  logic              levelLast;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= trigRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) levelLast <= 1'b0;
    else     levelLast <= syncChain[STAGES-1];
  end

  assign trigLevel = syncChain[STAGES-1];
  assign trigRise  = syncChain[STAGES-1] & ~levelLast;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trigRise |=> !trigRise) else $error("rise lasted two cycles"); // R4
  AST_RISE_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
    $rose(syncChain[0]) |=> trigRise) else $error("edge lost in sync"); // R3

endmodule

// File: rtl/trig_cnt_ctrl.sv
module trig_cnt_ctrl
  import trig_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trigLevel,
  input  logic       trigRise,
  input  logic [2:0] modeIn,
  input  logic       modeWr,
  input  logic       dirUp,
  input  logic       loadStb,
  output cntStrb_t   strb,
  output logic       running
);

  logic [2:0] modeQ;
  logic       startLatch;
  logic       mayAdvance;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ      <= MODE_FREE;
      startLatch <= 1'b0;
    end else if (modeWr) begin
      modeQ      <= modeIn;
      startLatch <= 1'b0;
    end else if (modeQ == MODE_START && trigRise) begin
      startLatch <= 1'b1;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_FREE:  mayAdvance = 1'b1;
      MODE_GATE:  mayAdvance = trigLevel;
      MODE_START: mayAdvance = startLatch;
      default:    mayAdvance = 1'b0;
    endcase
  end

  assign strb.load    = loadStb;
  assign strb.advance = mayAdvance;
  assign strb.countUp = dirUp;
  assign running      = mayAdvance;

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    modeWr |=> !startLatch) else $error("latch survived mode write"); // R5
  AST_IDLE_CODES: assert property (@(posedge clk) disable iff (rst)
    (modeQ != MODE_FREE && modeQ != MODE_GATE && modeQ != MODE_START) |-> !running)
    else $error("unused code counts"); // R6
  AST_FREE_RUNS: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_FREE) |-> running) else $error("free mode stalled"); // R2
  AST_GATE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_GATE) |-> (running == trigLevel)) else $error("gate mismatch"); // R3
  AST_LATCH_STICKS: assert property (@(posedge clk) disable iff (rst)
    (startLatch && !modeWr) |=> startLatch) else $error("latch dropped"); // R4

endmodule

// File: rtl/trig_cnt_dp.sv
module trig_cnt_dp
  import trig_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrb_t         strb,
  input  logic [CNT_W-1:0] presetVal,
  input  logic [CNT_W-1:0] reloadLim,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] stepUp;
  logic [CNT_W-1:0] stepDown;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    stepUp   = (count == reloadLim) ? '0 : count + ONE;
    stepDown = (count == '0) ? reloadLim : count - ONE;
    if (strb.load)         countNext = presetVal;
    else if (strb.advance) countNext = strb.countUp ? stepUp : stepDown;
    else                   countNext = count;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= countNext;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> count == $past(presetVal)) else $error("load lost"); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.advance) |=> $stable(count)) else $error("count drifted"); // R6
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && strb.advance && strb.countUp && count == reloadLim) |=> count == '0)
    else $error("up wrap wrong"); // R7
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && strb.advance && !strb.countUp && count == '0 && $stable(reloadLim))
    |=> count == $past(reloadLim)) else $error("down wrap wrong"); // R7

endmodule

// File: rtl/trig_cnt.sv
module trig_cnt
  import trig_cnt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigIn,
  input  logic [2:0]       modeIn,
  input  logic             modeWr,
  input  logic             dirUp,
  input  logic [CNT_W-1:0] presetVal,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] reloadLim,
  output logic [CNT_W-1:0] count,
  output logic             running
);

  logic     trigLevel;
  logic     trigRise;
  cntStrb_t strb;

  trig_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .trigRaw  (trigIn),
    .trigLevel(trigLevel),
    .trigRise (trigRise)
  );

  trig_cnt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trigLevel(trigLevel),
    .trigRise (trigRise),
    .modeIn   (modeIn),
    .modeWr   (modeWr),
    .dirUp    (dirUp),
    .loadStb  (loadStb),
    .strb     (strb),
    .running  (running)
  );

  trig_cnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .presetVal(presetVal),
    .reloadLim(reloadLim),
    .count    (count)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && running)) else $error("reset state wrong"); // R1

endmodule

// File: tb/trig_cnt_tb.sv
module trig_cnt_tb;

  localparam int W = 8;
  localparam int NV = 38;

  typedef struct packed {
    logic       wr;
    logic [2:0] mode;
    logic       trig;
    logic       up;
    logic       ld;
    logic [7:0] pre;
    logic [7:0] expCnt;
    logic       expRun;
    logic [3:0] req;
  } vec_t;

  // columns: wr mode trig up ld pre | count running | requirement
  localparam vec_t TBL [NV] = '{
    '{1'b0,3'd0,1'b0,1'b1,1'b1,8'd7,8'd7,1'b1,4'd8},  // R8 load
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd8,1'b1,4'd2},  // R2
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd9,1'b1,4'd2},  // R2 trigger ignored
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd0,1'b1,4'd7},  // R7 up wrap
    '{1'b0,3'd0,1'b1,1'b0,1'b0,8'd0,8'd9,1'b1,4'd7},  // R7 down wrap
    '{1'b0,3'd0,1'b0,1'b0,1'b0,8'd0,8'd8,1'b1,4'd7},
    '{1'b1,3'd5,1'b0,1'b0,1'b0,8'd0,8'd7,1'b0,4'd9},  // R9 gated, low
    '{1'b0,3'd0,1'b0,1'b0,1'b0,8'd0,8'd7,1'b0,4'd3},  // R3 hold
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd7,1'b0,4'd3},  // R3 sync stage 1
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd7,1'b1,4'd3},  // R3 stage 2
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd8,1'b1,4'd3},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd9,1'b1,4'd3},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd0,1'b0,4'd3},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd0,1'b0,4'd3},
    '{1'b1,3'd6,1'b0,1'b1,1'b0,8'd0,8'd0,1'b0,4'd4},  // R4 start mode
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd0,1'b0,4'd4},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd0,1'b0,4'd4},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd0,1'b1,4'd4},  // R4 latch set
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd1,1'b1,4'd4},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd2,1'b1,4'd4},  // R4 stays on when low
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd3,1'b1,4'd4},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd4,1'b1,4'd4},  // R4 second edge no restart
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd5,1'b1,4'd4},
    '{1'b1,3'd6,1'b1,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},  // R5 rewrite clears
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},  // R5 level alone idle
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd6,1'b0,4'd5},
    '{1'b0,3'd0,1'b1,1'b1,1'b0,8'd0,8'd6,1'b1,4'd5},  // R5 fresh edge arms
    '{1'b0,3'd0,1'b1,1'b0,1'b0,8'd0,8'd5,1'b1,4'd7},  // R7 down in start mode
    '{1'b1,3'd3,1'b0,1'b1,1'b0,8'd0,8'd6,1'b0,4'd6},  // R6 unused code
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd6,1'b0,4'd6},
    '{1'b0,3'd0,1'b1,1'b1,1'b1,8'd2,8'd2,1'b0,4'd8},  // R8 load while idle
    '{1'b1,3'd0,1'b1,1'b1,1'b0,8'd0,8'd2,1'b1,4'd2},
    '{1'b0,3'd0,1'b1,1'b0,1'b0,8'd0,8'd1,1'b1,4'd2},
    '{1'b0,3'd0,1'b0,1'b1,1'b1,8'd5,8'd5,1'b1,4'd8},  // R8 load beats advance
    '{1'b0,3'd0,1'b0,1'b1,1'b0,8'd0,8'd6,1'b1,4'd7}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trigIn = 1'b0;
  logic [2:0]   modeIn = 3'd0;
  logic         modeWr = 1'b0;
  logic         dirUp = 1'b1;
  logic [W-1:0] presetVal = '0;
  logic         loadStb = 1'b0;
  logic [W-1:0] reloadLim = 8'd9;
  logic [W-1:0] count;
  logic         running;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trig_cnt #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .trigIn(trigIn), .modeIn(modeIn), .modeWr(modeWr),
    .dirUp(dirUp), .presetVal(presetVal), .loadStb(loadStb),
    .reloadLim(reloadLim), .count(count), .running(running)
  );

  task automatic check(input int reqNum, input logic [W-1:0] eCnt, input logic eRun);
    nChecks++;
    if (count !== eCnt || running !== eRun) begin
      nFails++;
      $display("FAIL R%0d: count=%0d running=%0b expected count=%0d running=%0b",
               reqNum, count, running, eCnt, eRun);
    end
  endtask

  task automatic stepIdle();
    @(negedge clk);
    modeWr = 1'b0; loadStb = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2 check(1, 8'd0, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (i != 0) @(negedge clk);
      modeWr = TBL[i].wr; modeIn = TBL[i].mode; trigIn = TBL[i].trig;
      dirUp = TBL[i].up; loadStb = TBL[i].ld; presetVal = TBL[i].pre;
      @(posedge clk); #2;
      check(int'(TBL[i].req), TBL[i].expCnt, TBL[i].expRun);
    end

    // R7 reload limit lowered mid-run: 6 -> 7 -> 0
    @(negedge clk);
    loadStb = 1'b0; modeWr = 1'b0; dirUp = 1'b1; reloadLim = 8'd7;
    @(posedge clk); #2 check(7, 8'd7, 1'b1);
    stepIdle(); check(7, 8'd0, 1'b1);
    // R7 down from zero wraps to new limit
    @(negedge clk); dirUp = 1'b0;
    @(posedge clk); #2 check(7, 8'd7, 1'b1);

    // R6 code 7 holds the count
    @(negedge clk); modeIn = 3'd7; modeWr = 1'b1;
    @(posedge clk); #2 check(6, 8'd6, 1'b0);
    stepIdle(); check(6, 8'd6, 1'b0);

    // R1 reset mid-run restores zero and free mode
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2 check(1, 8'd0, 1'b1);
    @(negedge clk); rst = 1'b0; dirUp = 1'b1;
    @(posedge clk); #2 check(2, 8'd1, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule